// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a slave for a two-wire serial bus that places a byte-wide register file behind a 16-bit register pointer. A system clock oversamples the clock and data lines. After a start condition the block matches a 7-bit device address. It then either takes a two-byte pointer followed by data bytes to write, or returns register bytes to the master. The pointer steps by one after every data byte in either direction, so consecutive bytes reach consecutive registers. A repeated start keeps the pointer, which is how a master sets up a read. The block drives the data line only through an active-high pull-low enable.

The block also answers to a second device address. That address is held in a register inside the block, which is reached at a fixed pointer value. The register-side port is plain and has no back-pressure. A write is a one-cycle strobe that the register file must accept. A read is combinational: the register file must present `reg_rdata` for `reg_addr` in the same cycle.

Top module: `twowire_reg_slave`

## Requirements
- R1: After reset `sda_oe` is 0, `reg_wr_en` is 0 and `reg_addr` is 16'h0000.
- R2: The first byte after a start is sent MSB first. Its upper seven bits are the device address and its lowest bit is the direction, where 0 is write and 1 is read. The block pulls the line low in the ninth clock only when the address matches. On a mismatch it never pulls the line low, and it issues no write, until the next start.
- R3: The block also acknowledges the alternate address, which is 7'h36 after reset. A data byte written at pointer 16'hFF00 loads its low seven bits into the alternate address and raises no `reg_wr_en`. A read at pointer 16'hFF00 returns {1'b0, alternate address}.
- R4: In a write, two pointer bytes follow the address byte, high byte first, and each is acknowledged. Each data byte after them is acknowledged. Each data byte then produces a one-cycle `reg_wr_en` with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer is one higher on the next cycle, with the carry crossing from the low byte into the high byte.
- R5: In a read, the block sends the byte at the current pointer MSB first, then advances the pointer. It sends the next byte each time the master acknowledges.
- R6: After a master no-acknowledge in a read, the block stops driving. It pulls the line low for no clock until the next start.
- R7: `sda_oe` changes only while the clock line is low.
- R8: A stop at any bit position returns the block to idle without a write for the partial byte. A start at any bit position begins a new address byte, and the pointer keeps the value set by completed pointer bytes and steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | 16 | Register pointer |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Write data for the strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr`, same cycle |

## Verification
The bench sweeps all 128 device addresses. A matcher with a wrong compare would acknowledge a stranger's address or miss its own. It writes a burst across a low-byte boundary, which exposes a pointer that loses its carry or steps at the wrong moment: the write log would show repeated or skipped addresses. It aborts a data byte with a stop and, separately, with a repeated start. A design that commits partial bytes would write garbage, and one that clears the pointer would read the wrong register. It reprograms the alternate address and checks that the old address falls silent. It also clocks the bus after a read no-acknowledge, where a slave that kept driving would corrupt the line.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_RX,
    ST_ACK_R,
    ST_TX,
    ST_ACK_T
  } twr_state_t;
endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p;
  logic [STAGES-1:0] sda_p;
  logic scl_d, sda_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_p[0] <= 1'b1;
          sda_p[0] <= 1'b1;
        end else begin
          scl_p[0] <= scl_in;
          sda_p[0] <= sda_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_p[g] <= 1'b1;
          sda_p[g] <= 1'b1;
        end else begin
          scl_p[g] <= scl_p[g-1];
          sda_p[g] <= sda_p[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges while the clock stays high mark bus conditions
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twr_addr_match.sv
module twr_addr_match #(
  parameter logic [6:0] DEV_ADDR  = 7'h10,
  parameter logic [6:0] ALT_RESET = 7'h36
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] cand,
  input  logic       load,
  input  logic [6:0] load_val,
  output logic       hit,
  output logic [6:0] alt_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    alt_addr <= ALT_RESET;
    else if (load) alt_addr <= load_val;
  end

  assign hit = (cand == DEV_ADDR) || (cand == alt_addr);
endmodule

// File: rtl/twowire_reg_slave.sv
module twowire_reg_slave
  import twr_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR     = 7'h10,
  parameter logic [6:0]  ALT_RESET    = 7'h36,
  parameter logic [15:0] ALT_REG_ADDR = 16'hFF00,
  parameter int          SYNC_N       = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_oe,
  output logic [15:0] reg_addr,
  output logic        reg_wr_en,
  output logic [7:0]  reg_wdata,
  input  logic [7:0]  reg_rdata
);
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 2 * BYTE_W;
  localparam logic [3:0] BITS = 4'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  twr_state_t state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, wdata, rd_byte;
  logic [PTR_W-1:0]  ptr;
  logic [1:0]        rx_idx;
  logic              rw, m_ack, alt_wr, addr_hit, alt_sel;
  logic [6:0]        alt_addr;

  twr_line_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twr_addr_match #(.DEV_ADDR(DEV_ADDR), .ALT_RESET(ALT_RESET)) u_match (
    .clk(clk), .rst_n(rst_n), .cand(rx_sh[7:1]), .load(alt_wr),
    .load_val(wdata[6:0]), .hit(addr_hit), .alt_addr(alt_addr)
  );

  always_comb begin
    alt_sel = (ptr == ALT_REG_ADDR);
    rd_byte = alt_sel ? {1'b0, alt_addr} : reg_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      wdata     <= '0;
      ptr       <= '0;
      rx_idx    <= '0;
      rw        <= 1'b0;
      m_ack     <= 1'b0;
      sda_oe    <= 1'b0;
      reg_wr_en <= 1'b0;
      alt_wr    <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      alt_wr    <= 1'b0;
      if (reg_wr_en || alt_wr) ptr <= ptr + 1'b1;

      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR, ST_RX: begin
            if (scl_rise && cnt < BITS) begin
              rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == BITS) begin
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  rw     <= rx_sh[0];
                  state  <= ST_ACK_A;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_ACK_R;
                unique case (rx_idx)
                  2'd0:    ptr[PTR_W-1:BYTE_W] <= rx_sh;
                  2'd1:    ptr[BYTE_W-1:0]     <= rx_sh;
                  default: wdata               <= rx_sh;
                endcase
              end
            end
          end
          ST_ACK_A: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx_sh  <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                ptr    <= ptr + 1'b1;
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                rx_idx <= '0;
                state  <= ST_RX;
              end
            end
          end
          ST_ACK_R: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_RX;
              if (rx_idx == 2'd2) begin
                if (alt_sel) alt_wr    <= 1'b1;
                else         reg_wr_en <= 1'b1;
              end else begin
                rx_idx <= rx_idx + 1'b1;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == BITS - 4'd1) begin
                sda_oe <= 1'b0;
                state  <= ST_ACK_T;
              end else begin
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx_sh[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_ACK_T: begin
            if (scl_rise) m_ack <= ~sda_s;
            if (scl_fall) begin
              if (m_ack) begin
                tx_sh  <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                ptr    <= ptr + 1'b1;
                cnt    <= '0;
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign reg_addr  = ptr;
  assign reg_wdata = wdata;
endmodule

// File: rtl/twr_checker.sv
module twr_checker
  import twr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        reg_wr_en,
  input logic [15:0] reg_addr,
  input logic        scl_s,
  input logic        start_det,
  input logic        stop_det,
  input twr_state_t  state
);
  assert_oe_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> (reg_addr == $past(reg_addr) + 16'd1));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe));

  assert_start_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state == ST_ADDR));
endmodule

bind twowire_reg_slave twr_checker u_twr_checker (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .reg_wr_en(reg_wr_en),
  .reg_addr(reg_addr), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .state(state)
);

// File: tb/test_twowire_reg_slave.sv
module test_twowire_reg_slave;
  localparam logic [6:0]  DEV    = 7'h10;
  localparam logic [6:0]  ALT0   = 7'h36;
  localparam logic [15:0] ALTREG = 16'hFF00;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, reg_wr_en;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  wire sda_line = m_sda & ~sda_oe;

  logic [7:0]  mem [256];
  logic [15:0] wl_addr [64];
  logic [7:0]  wl_data [64];
  int wl_n = 0;
  int oe_bad = 0;
  logic oe_prev = 1'b0;
  int checks = 0, fails = 0;

  twowire_reg_slave i_twowire_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (reg_wr_en) begin
      mem[reg_addr[7:0]] <= reg_wdata;
      if (wl_n < 64) begin
        wl_addr[wl_n] <= reg_addr;
        wl_data[wl_n] <= reg_wdata;
      end
      wl_n <= wl_n + 1;
    end
  end

  // R7 monitor: the pull-low enable may only move while the clock is low
  always @(posedge clk) begin
    if (rst_n && (sda_oe != oe_prev) && m_scl) oe_bad <= oe_bad + 1;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] expv(input logic [15:0] a);
    return a[7:0] * 8'd7 + 8'd3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic sbit(input bit b, output bit s);
    m_sda = b; waitq();
    m_scl = 1'b1; waitq();
    s = sda_line; waitq();
    m_scl = 1'b0; waitq();
  endtask

  task automatic bstart();
    m_sda = 1'b1; waitq();
    m_scl = 1'b1; waitq();
    m_sda = 1'b0; waitq();
    m_scl = 1'b0; waitq();
  endtask

  task automatic bstop();
    m_sda = 1'b0; waitq();
    m_scl = 1'b1; waitq();
    m_sda = 1'b1; waitq();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) sbit(b[i], s);
    sbit(1'b1, s);
    ack = !s;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      sbit(1'b1, s);
      b[i] = s;
    end
    sbit(!mack, s);
  endtask

  task automatic set_ptr(input logic [6:0] dev, input logic [15:0] p);
    bit a;
    bstart();
    wbyte({dev, 1'b0}, a); chk(a, "R4 addr ack", a, 1);
    wbyte(p[15:8], a);     chk(a, "R4 ptr hi ack", a, 1);
    wbyte(p[7:0], a);      chk(a, "R4 ptr lo ack", a, 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    bit a, s;
    logic [7:0] d;
    int base;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
    chk(reg_wr_en == 1'b0, "R1 reg_wr_en", int'(reg_wr_en), 0);
    chk(reg_addr == 16'h0, "R1 reg_addr", int'(reg_addr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2/R3 sweep of every device address
    for (int ad = 0; ad < 128; ad++) begin
      bit exp_ack;
      bstart();
      wbyte({7'(ad), 1'b0}, a);
      bstop();
      exp_ack = (7'(ad) == DEV) || (7'(ad) == ALT0);
      chk(a == exp_ack, "R2 R3 address sweep ack", int'(a), int'(exp_ack));
    end

    // R2 a stranger's transaction is ignored
    base = wl_n;
    bstart();
    wbyte({7'h11, 1'b0}, a); chk(!a, "R2 stranger addr", int'(a), 0);
    wbyte(8'h00, a);         chk(!a, "R2 stranger byte1", int'(a), 0);
    wbyte(8'h05, a);         chk(!a, "R2 stranger byte2", int'(a), 0);
    wbyte(8'hEE, a);         chk(!a, "R2 stranger byte3", int'(a), 0);
    bstop();
    chk(wl_n == base, "R2 no write for stranger", wl_n - base, 0);

    // R4 write burst across a low-byte boundary
    base = wl_n;
    set_ptr(DEV, 16'h12FE);
    for (int i = 0; i < 4; i++) begin
      wbyte(expv(16'h12FE + 16'(i)), a);
      chk(a, "R4 data ack", int'(a), 1);
    end
    bstop();
    repeat (4) @(negedge clk);
    chk(wl_n - base == 4, "R4 strobe count", wl_n - base, 4);
    for (int i = 0; i < 4; i++) begin
      chk(wl_addr[base+i] == 16'h12FE + 16'(i), "R4 strobe addr",
          int'(wl_addr[base+i]), 32'h12FE + i);
      chk(wl_data[base+i] == expv(16'h12FE + 16'(i)), "R4 strobe data",
          int'(wl_data[base+i]), int'(expv(16'h12FE + 16'(i))));
    end
    chk(reg_addr == 16'h1302, "R4 pointer after burst", int'(reg_addr), 32'h1302);

    // R5 read back through a repeated start
    set_ptr(DEV, 16'h12FE);
    bstart();
    wbyte({DEV, 1'b1}, a); chk(a, "R5 read addr ack", int'(a), 1);
    for (int i = 0; i < 4; i++) begin
      rbyte(i != 3, d);
      chk(d == expv(16'h12FE + 16'(i)), "R5 read data", int'(d),
          int'(expv(16'h12FE + 16'(i))));
    end

    // R6 after the no-acknowledge the block stays off the line
    begin
      int lows = 0;
      for (int i = 0; i < 9; i++) begin
        sbit(1'b1, s);
        if (!s) lows++;
      end
      chk(lows == 0, "R6 line released after nack", lows, 0);
    end
    bstop();

    // R8 pointer kept across a new start
    bstart();
    wbyte({DEV, 1'b1}, a); chk(a, "R8 read addr ack", int'(a), 1);
    rbyte(1'b0, d);
    chk(d == (8'h02 ^ 8'hA5), "R8 pointer retained", int'(d), 32'hA7);
    bstop();

    // R8 stop in mid data byte
    base = wl_n;
    set_ptr(DEV, 16'h0040);
    sbit(1'b1, s); sbit(1'b0, s); sbit(1'b1, s);
    bstop();
    chk(wl_n == base, "R8 stop aborts write", wl_n - base, 0);
    bstart();
    wbyte({DEV, 1'b1}, a);
    rbyte(1'b0, d);
    chk(d == (8'h40 ^ 8'hA5), "R8 pointer after stop", int'(d), 32'hE5);
    bstop();

    // R8 repeated start in mid data byte
    base = wl_n;
    set_ptr(DEV, 16'h0050);
    for (int i = 0; i < 4; i++) sbit(1'b0, s);
    bstart();
    wbyte({DEV, 1'b1}, a); chk(a, "R8 restart addr ack", int'(a), 1);
    rbyte(1'b0, d);
    chk(d == (8'h50 ^ 8'hA5), "R8 pointer after restart", int'(d), 32'hF5);
    bstop();
    chk(wl_n == base, "R8 restart aborts write", wl_n - base, 0);

    // R3 reprogram the alternate address
    base = wl_n;
    set_ptr(DEV, ALTREG);
    wbyte(8'h55, a); chk(a, "R3 alt data ack", int'(a), 1);
    bstop();
    repeat (4) @(negedge clk);
    chk(wl_n == base, "R3 no strobe for alt reg", wl_n - base, 0);
    bstart(); wbyte({7'h55, 1'b0}, a); bstop();
    chk(a, "R3 new alt acks", int'(a), 1);
    bstart(); wbyte({ALT0, 1'b0}, a); bstop();
    chk(!a, "R3 old alt silent", int'(a), 0);
    set_ptr(7'h55, ALTREG);
    bstart();
    wbyte({7'h55, 1'b1}, a); chk(a, "R3 alt read ack", int'(a), 1);
    rbyte(1'b0, d);
    chk(d == 8'h55, "R3 alt read back", int'(d), 32'h55);
    bstop();
    base = wl_n;
    set_ptr(7'h55, 16'h0003);
    wbyte(8'h9C, a); chk(a, "R3 write via alt ack", int'(a), 1);
    bstop();
    repeat (4) @(negedge clk);
    chk(wl_n - base == 1 && wl_addr[base] == 16'h0003 && wl_data[base] == 8'h9C,
        "R3 write via alt", int'(wl_data[base]), 32'h9C);

    chk(oe_bad == 0, "R7 oe moved while clock high", oe_bad, 0);
    summary();
    $finish;
  end
endmodule